// File: doc/BRIEF.md
# Call-Aware Register File

A 64-bit register file for a small packet-filter style processor. It holds ten general registers (indices 0 to 9) and one frame-pointer register (index 10) that programs may read but never write. Next to every register it keeps a readable flag. These flags model the call convention. Scratch registers lose their meaning when a helper call returns. Callee-saved registers keep theirs. A program starts out with only its context argument and the frame pointer available.

The datapath drives two combinational read ports, named dst and src, and one write port. The write port stores either the full 64 bits or only the low 32 bits. A narrow write clears the upper half. A start strobe begins a program: it loads the context value and the frame-pointer value and resets the flags. A call-return strobe captures the helper's return value and applies the clobber rule. A sticky error output reports reads of unreadable registers, out-of-range indices and attempts to write the frame pointer.

Top module: `callreg_file`

## Requirements
- R1: After reset every readable flag is clear, err_o is 0 and both read ports return 0 for every index.
- R2: A start_i cycle loads ctx_i into register 1 and fp_i into register 10, leaves only registers 1 and 10 readable, and clears err_o. start_i takes priority over call_done_i and wr_en_i in the same cycle, and those two are discarded.
- R3: A write with wr_wide_i=1 to an index from 0 to 9 stores all 64 bits of wr_data_i and marks that register readable. The new value is visible on the read ports in the cycle after the write edge.
- R4: A write with wr_wide_i=0 stores wr_data_i[31:0] in the low half, stores zero in bits 63:32, and marks the register readable.
- R5: A read port that selects an unreadable register, or an index above 10, returns 0 combinationally. If its enable (rd_dst_en_i or rd_src_en_i) is 1, err_o is 1 from the next clock edge.
- R6: A write to index 10 or above sets err_o at the next edge and changes no register contents and no flag.
- R7: A call_done_i cycle loads ret_val_i into register 0 and marks it readable.
- R8: A call_done_i cycle clears the readable flags of registers 1 to 5. Afterwards they read as 0, and an enabled read of one of them sets err_o.
- R9: Registers 6 to 9 and register 10 keep their values and flags across call_done_i.
- R10: A write in the same cycle as call_done_i is discarded entirely, including any error it would raise.
- R11: err_o stays 1 once set, until the next start_i or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Program start strobe |
| ctx_i | input | 64 | Context value loaded into register 1 on start |
| fp_i | input | 64 | Frame-pointer value loaded into register 10 on start |
| call_done_i | input | 1 | Helper call has returned |
| ret_val_i | input | 64 | Helper return value |
| wr_en_i | input | 1 | Write enable |
| wr_idx_i | input | 4 | Write register index |
| wr_wide_i | input | 1 | 1 = 64-bit write, 0 = 32-bit zero-extended write |
| wr_data_i | input | 64 | Write data |
| rd_dst_en_i | input | 1 | dst read is architecturally used (error check enable) |
| rd_dst_idx_i | input | 4 | dst read index |
| rd_dst_data_o | output | 64 | dst read data, 0 if unreadable |
| rd_src_en_i | input | 1 | src read is architecturally used (error check enable) |
| rd_src_idx_i | input | 4 | src read index |
| rd_src_data_o | output | 64 | src read data, 0 if unreadable |
| err_o | output | 1 | Sticky error flag |

## Verification
Read data is combinational, so the bench settles a read index and samples within the same cycle. Writes, start and call-return effects go through one register stage. The bench drives a stimulus one time unit after a rising edge and samples its result one time unit after the following edge. err_o is also one register stage behind the offending read or write, so each error check samples it after exactly one edge. Stickiness is then confirmed several cycles later with clean inputs.

// File: rtl/callreg_pkg.sv
package callreg_pkg;
  localparam int unsigned DATA_W   = 64;
  localparam int unsigned IDX_W    = 4;
  localparam int unsigned NUM_REGS = 11;
  localparam int unsigned RET_IDX  = 0;
  localparam int unsigned CTX_IDX  = 1;
  localparam int unsigned ARG_LO   = 1;
  localparam int unsigned ARG_HI   = 5;

  // Per-cycle update chosen by priority: start > call > write
  typedef enum logic [1:0] {
    UPD_NONE  = 2'd0,
    UPD_START = 2'd1,
    UPD_CALL  = 2'd2,
    UPD_WRITE = 2'd3
  } upd_e;
endpackage

// File: rtl/callreg_ctrl.sv
module callreg_ctrl
  import callreg_pkg::*;
#(
  parameter int unsigned IDX_W    = callreg_pkg::IDX_W,
  parameter int unsigned NUM_REGS = callreg_pkg::NUM_REGS
) (
  input  logic             start_i,
  input  logic             call_done_i,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  output upd_e             upd_o,
  output logic             wr_ok_o,
  output logic             wr_bad_o
);
  localparam logic [IDX_W-1:0] FP_IDX = IDX_W'(NUM_REGS - 1);

  always_comb begin
    upd_o = UPD_NONE;
    if (start_i)          upd_o = UPD_START;
    else if (call_done_i) upd_o = UPD_CALL;
    else if (wr_en_i)     upd_o = UPD_WRITE;
  end

  assign wr_ok_o  = (upd_o == UPD_WRITE) && (wr_idx_i <  FP_IDX);
  assign wr_bad_o = (upd_o == UPD_WRITE) && (wr_idx_i >= FP_IDX);
endmodule

// File: rtl/callreg_flags.sv
module callreg_flags
  import callreg_pkg::*;
#(
  parameter int unsigned IDX_W    = callreg_pkg::IDX_W,
  parameter int unsigned NUM_REGS = callreg_pkg::NUM_REGS,
  parameter int unsigned RET_IDX  = callreg_pkg::RET_IDX,
  parameter int unsigned CTX_IDX  = callreg_pkg::CTX_IDX,
  parameter int unsigned ARG_LO   = callreg_pkg::ARG_LO,
  parameter int unsigned ARG_HI   = callreg_pkg::ARG_HI
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  upd_e                upd_i,
  input  logic                wr_ok_i,
  input  logic [IDX_W-1:0]    wr_idx_i,
  output logic [NUM_REGS-1:0] valid_o
);
  localparam int unsigned FP_IDX = NUM_REGS - 1;

  logic [NUM_REGS-1:0] valid_q, valid_d;

  always_comb begin
    valid_d = valid_q;
    unique case (upd_i)
      UPD_START: begin
        valid_d          = '0;
        valid_d[CTX_IDX] = 1'b1;
        valid_d[FP_IDX]  = 1'b1;
      end
      UPD_CALL: begin
        for (int i = ARG_LO; i <= ARG_HI; i++) valid_d[i] = 1'b0;
        valid_d[RET_IDX] = 1'b1;
      end
      UPD_WRITE: begin
        for (int i = 0; i < FP_IDX; i++)
          if (wr_ok_i && (wr_idx_i == IDX_W'(i))) valid_d[i] = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= '0;
    else         valid_q <= valid_d;
  end

  assign valid_o = valid_q;
endmodule

// File: rtl/callreg_store.sv
module callreg_store
  import callreg_pkg::*;
#(
  parameter int unsigned DATA_W   = callreg_pkg::DATA_W,
  parameter int unsigned IDX_W    = callreg_pkg::IDX_W,
  parameter int unsigned NUM_REGS = callreg_pkg::NUM_REGS,
  parameter int unsigned RET_IDX  = callreg_pkg::RET_IDX,
  parameter int unsigned CTX_IDX  = callreg_pkg::CTX_IDX
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  upd_e                             upd_i,
  input  logic [DATA_W-1:0]                ctx_i,
  input  logic [DATA_W-1:0]                fp_i,
  input  logic [DATA_W-1:0]                ret_val_i,
  input  logic                             wr_ok_i,
  input  logic [IDX_W-1:0]                 wr_idx_i,
  input  logic                             wr_wide_i,
  input  logic [DATA_W-1:0]                wr_data_i,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  regs_o
);
  localparam int unsigned FP_IDX = NUM_REGS - 1;
  localparam int unsigned HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] wr_ext;
  assign wr_ext = wr_wide_i ? wr_data_i : {{HALF_W{1'b0}}, wr_data_i[HALF_W-1:0]};

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [DATA_W-1:0] q;
    if (g == FP_IDX) begin : g_fp
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                 q <= '0;
        else if (upd_i == UPD_START) q <= fp_i;
      end
    end else begin : g_gpr
      logic ld_ctx, ld_ret, ld_wr;
      assign ld_ctx = (upd_i == UPD_START) && (g == CTX_IDX);
      assign ld_ret = (upd_i == UPD_CALL)  && (g == RET_IDX);
      assign ld_wr  = wr_ok_i && (wr_idx_i == IDX_W'(g));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     q <= '0;
        else if (ld_ctx) q <= ctx_i;
        else if (ld_ret) q <= ret_val_i;
        else if (ld_wr)  q <= wr_ext;
      end
    end
    assign regs_o[g] = q;
  end
endmodule

// File: rtl/callreg_rdport.sv
module callreg_rdport #(
  parameter int unsigned DATA_W   = callreg_pkg::DATA_W,
  parameter int unsigned IDX_W    = callreg_pkg::IDX_W,
  parameter int unsigned NUM_REGS = callreg_pkg::NUM_REGS
) (
  input  logic [NUM_REGS-1:0][DATA_W-1:0] regs_i,
  input  logic [NUM_REGS-1:0]             valid_i,
  input  logic                            en_i,
  input  logic [IDX_W-1:0]                idx_i,
  output logic [DATA_W-1:0]               data_o,
  output logic                            bad_o
);
  logic hit;

  always_comb begin
    data_o = '0;
    hit    = 1'b0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (idx_i == IDX_W'(i) && valid_i[i]) begin
        data_o = regs_i[i];
        hit    = 1'b1;
      end
    end
  end

  assign bad_o = en_i && !hit;
endmodule

// File: rtl/callreg_file.sv
module callreg_file
  import callreg_pkg::*;
#(
  parameter int unsigned DATA_W   = callreg_pkg::DATA_W,
  parameter int unsigned IDX_W    = callreg_pkg::IDX_W,
  parameter int unsigned NUM_REGS = callreg_pkg::NUM_REGS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] ctx_i,
  input  logic [DATA_W-1:0] fp_i,
  input  logic              call_done_i,
  input  logic [DATA_W-1:0] ret_val_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic              wr_wide_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_dst_en_i,
  input  logic [IDX_W-1:0]  rd_dst_idx_i,
  output logic [DATA_W-1:0] rd_dst_data_o,
  input  logic              rd_src_en_i,
  input  logic [IDX_W-1:0]  rd_src_idx_i,
  output logic [DATA_W-1:0] rd_src_data_o,
  output logic              err_o
);
  localparam int unsigned NUM_RD = 2;

  upd_e                            upd;
  logic                            wr_ok, wr_bad;
  logic [NUM_REGS-1:0]             valid;
  logic [NUM_REGS-1:0][DATA_W-1:0] regs;
  logic [NUM_RD-1:0]               rd_en, rd_bad;
  logic [NUM_RD-1:0][IDX_W-1:0]    rd_idx;
  logic [NUM_RD-1:0][DATA_W-1:0]   rd_data;
  logic                            err_q;

  callreg_ctrl #(.IDX_W(IDX_W), .NUM_REGS(NUM_REGS)) u_ctrl (
    .start_i    (start_i),
    .call_done_i(call_done_i),
    .wr_en_i    (wr_en_i),
    .wr_idx_i   (wr_idx_i),
    .upd_o      (upd),
    .wr_ok_o    (wr_ok),
    .wr_bad_o   (wr_bad)
  );

  callreg_flags #(.IDX_W(IDX_W), .NUM_REGS(NUM_REGS)) u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .upd_i   (upd),
    .wr_ok_i (wr_ok),
    .wr_idx_i(wr_idx_i),
    .valid_o (valid)
  );

  callreg_store #(.DATA_W(DATA_W), .IDX_W(IDX_W), .NUM_REGS(NUM_REGS)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .upd_i    (upd),
    .ctx_i    (ctx_i),
    .fp_i     (fp_i),
    .ret_val_i(ret_val_i),
    .wr_ok_i  (wr_ok),
    .wr_idx_i (wr_idx_i),
    .wr_wide_i(wr_wide_i),
    .wr_data_i(wr_data_i),
    .regs_o   (regs)
  );

  assign rd_en[0]  = rd_dst_en_i;
  assign rd_idx[0] = rd_dst_idx_i;
  assign rd_en[1]  = rd_src_en_i;
  assign rd_idx[1] = rd_src_idx_i;

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    callreg_rdport #(.DATA_W(DATA_W), .IDX_W(IDX_W), .NUM_REGS(NUM_REGS)) u_rd (
      .regs_i (regs),
      .valid_i(valid),
      .en_i   (rd_en[p]),
      .idx_i  (rd_idx[p]),
      .data_o (rd_data[p]),
      .bad_o  (rd_bad[p])
    );
  end

  assign rd_dst_data_o = rd_data[0];
  assign rd_src_data_o = rd_data[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      err_q <= 1'b0;
    else if (start_i) err_q <= 1'b0;
    else if (|rd_bad || wr_bad) err_q <= 1'b1;
  end

  assign err_o = err_q;
endmodule

// File: rtl/callreg_file_chk.sv
module callreg_file_chk #(
  parameter int unsigned DATA_W   = callreg_pkg::DATA_W,
  parameter int unsigned IDX_W    = callreg_pkg::IDX_W,
  parameter int unsigned NUM_REGS = callreg_pkg::NUM_REGS
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [DATA_W-1:0] ctx_i,
  input logic              call_done_i,
  input logic [DATA_W-1:0] ret_val_i,
  input logic              wr_en_i,
  input logic [IDX_W-1:0]  wr_idx_i,
  input logic              wr_wide_i,
  input logic [IDX_W-1:0]  rd_dst_idx_i,
  input logic [DATA_W-1:0] rd_dst_data_o,
  input logic [IDX_W-1:0]  rd_src_idx_i,
  input logic [DATA_W-1:0] rd_src_data_o,
  input logic              err_o
);
  localparam logic [IDX_W-1:0] FP  = IDX_W'(NUM_REGS - 1);
  localparam logic [IDX_W-1:0] CTX = IDX_W'(callreg_pkg::CTX_IDX);
  localparam logic [IDX_W-1:0] RET = IDX_W'(callreg_pkg::RET_IDX);
  localparam logic [IDX_W-1:0] ALO = IDX_W'(callreg_pkg::ARG_LO);
  localparam logic [IDX_W-1:0] AHI = IDX_W'(callreg_pkg::ARG_HI);
  localparam int unsigned HALF_W = DATA_W / 2;

  p_start_ctx_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (rd_src_idx_i != CTX || rd_src_data_o == $past(ctx_i)));

  p_start_clear_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !err_o);

  p_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !start_i) |=> err_o);

  p_zext_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_wide_i && !start_i && !call_done_i && wr_idx_i < FP)
    |=> (rd_dst_idx_i != $past(wr_idx_i) || rd_dst_data_o[DATA_W-1:HALF_W] == '0));

  p_fp_write_err_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_idx_i >= FP && !start_i && !call_done_i) |=> err_o);

  p_ret_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (call_done_i && !start_i) |=> (rd_dst_idx_i != RET || rd_dst_data_o == $past(ret_val_i)));

  p_arg_clobber_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (call_done_i && !start_i) |=> (rd_src_idx_i < ALO || rd_src_idx_i > AHI || rd_src_data_o == '0));
endmodule

bind callreg_file callreg_file_chk #(
  .DATA_W(DATA_W), .IDX_W(IDX_W), .NUM_REGS(NUM_REGS)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .ctx_i        (ctx_i),
  .call_done_i  (call_done_i),
  .ret_val_i    (ret_val_i),
  .wr_en_i      (wr_en_i),
  .wr_idx_i     (wr_idx_i),
  .wr_wide_i    (wr_wide_i),
  .rd_dst_idx_i (rd_dst_idx_i),
  .rd_dst_data_o(rd_dst_data_o),
  .rd_src_idx_i (rd_src_idx_i),
  .rd_src_data_o(rd_src_data_o),
  .err_o        (err_o)
);

// File: tb/callreg_file_tb.sv
`timescale 1ns/1ps
module callreg_file_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [63:0] ctx_i = '0;
  logic [63:0] fp_i = '0;
  logic        call_done_i = 1'b0;
  logic [63:0] ret_val_i = '0;
  logic        wr_en_i = 1'b0;
  logic [3:0]  wr_idx_i = '0;
  logic        wr_wide_i = 1'b0;
  logic [63:0] wr_data_i = '0;
  logic        rd_dst_en_i = 1'b0;
  logic [3:0]  rd_dst_idx_i = '0;
  logic [63:0] rd_dst_data_o;
  logic        rd_src_en_i = 1'b0;
  logic [3:0]  rd_src_idx_i = '0;
  logic [63:0] rd_src_data_o;
  logic        err_o;

  int total = 0;
  int bad = 0;

  localparam logic [63:0] CTX = 64'h1111_2222_3333_4444;
  localparam logic [63:0] FPV = 64'h0000_7FFF_FFFF_F000;

  always #2.5 clk_i = ~clk_i;

  callreg_file u_dut (.*);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic rd(input logic [3:0] idx, output logic [63:0] d);
    rd_src_idx_i = idx;
    rd_dst_idx_i = idx;
    #0.5;
    d = rd_src_data_o;
  endtask

  task automatic do_start(input logic [63:0] c, input logic [63:0] f);
    start_i = 1'b1; ctx_i = c; fp_i = f;
    tick();
    start_i = 1'b0;
  endtask

  task automatic do_write(input logic [3:0] idx, input logic [63:0] d, input logic wide);
    wr_en_i = 1'b1; wr_idx_i = idx; wr_data_i = d; wr_wide_i = wide;
    tick();
    wr_en_i = 1'b0;
  endtask

  task automatic do_call(input logic [63:0] r);
    call_done_i = 1'b1; ret_val_i = r;
    tick();
    call_done_i = 1'b0;
  endtask

  task automatic bad_read(input logic [3:0] idx);
    rd_src_en_i = 1'b1; rd_src_idx_i = idx;
    tick();
    rd_src_en_i = 1'b0;
  endtask

  task automatic t_reset();
    logic [63:0] d;
    check("R1 err after reset", {63'd0, err_o}, 64'd0);
    rd(4'd1, d);  check("R1 reg1 reads 0", d, 64'd0);
    rd(4'd10, d); check("R1 reg10 reads 0", d, 64'd0);
  endtask

  task automatic t_start();
    logic [63:0] d;
    do_start(CTX, FPV);
    rd(4'd1, d);  check("R2 ctx in reg1", d, CTX);
    rd(4'd10, d); check("R2 fp in reg10", d, FPV);
    rd(4'd0, d);  check("R2 reg0 unreadable", d, 64'd0);
    check("R2 err clear", {63'd0, err_o}, 64'd0);
  endtask

  task automatic t_write_wide();
    logic [63:0] d;
    do_write(4'd6, 64'hDEAD_BEEF_0123_4567, 1'b1);
    rd(4'd6, d); check("R3 wide write reg6", d, 64'hDEAD_BEEF_0123_4567);
    do_write(4'd0, 64'h8000_0000_0000_0001, 1'b1);
    rd(4'd0, d); check("R3 wide write reg0", d, 64'h8000_0000_0000_0001);
  endtask

  task automatic t_write_narrow();
    logic [63:0] d;
    do_write(4'd7, 64'hFFFF_FFFF_89AB_CDEF, 1'b0);
    rd(4'd7, d); check("R4 narrow write zero-extends", d, 64'h0000_0000_89AB_CDEF);
    do_write(4'd6, 64'hAAAA_AAAA_0000_0005, 1'b0);
    rd(4'd6, d); check("R4 narrow overwrite clears upper", d, 64'h0000_0000_0000_0005);
  endtask

  task automatic t_bad_read();
    logic [63:0] d;
    rd(4'd2, d); check("R5 unreadable reg2 returns 0", d, 64'd0);
    check("R5 no err without enable", {63'd0, err_o}, 64'd0);
    bad_read(4'd2);
    check("R5 err after enabled bad read", {63'd0, err_o}, 64'd1);
    repeat (4) tick();
    check("R11 err sticky", {63'd0, err_o}, 64'd1);
    do_start(CTX, FPV);
    check("R11 start clears err", {63'd0, err_o}, 64'd0);
    bad_read(4'd15);
    check("R5 err on index 15", {63'd0, err_o}, 64'd1);
    rd(4'd13, d); check("R5 index 13 reads 0", d, 64'd0);
    do_start(CTX, FPV);
  endtask

  task automatic t_fp_write();
    logic [63:0] d;
    do_write(4'd10, 64'h1234_5678_9ABC_DEF0, 1'b1);
    check("R6 err on reg10 write", {63'd0, err_o}, 64'd1);
    rd(4'd10, d); check("R6 reg10 unchanged", d, FPV);
    do_start(CTX, FPV);
    do_write(4'd12, 64'h55, 1'b1);
    check("R6 err on index 12 write", {63'd0, err_o}, 64'd1);
    rd(4'd1, d); check("R6 reg1 unchanged", d, CTX);
    do_start(CTX, FPV);
  endtask

  task automatic t_call();
    logic [63:0] d;
    for (int i = 2; i <= 9; i++) do_write(4'(i), 64'h100 + 64'(i), 1'b1);
    do_call(64'hCAFE_F00D_0000_0042);
    rd(4'd0, d); check("R7 ret in reg0", d, 64'hCAFE_F00D_0000_0042);
    for (int i = 1; i <= 5; i++) begin
      rd(4'(i), d); check("R8 arg reg clobbered", d, 64'd0);
    end
    for (int i = 6; i <= 9; i++) begin
      rd(4'(i), d); check("R9 callee-saved kept", d, 64'h100 + 64'(i));
    end
    rd(4'd10, d); check("R9 fp kept", d, FPV);
    check("R8 no err yet", {63'd0, err_o}, 64'd0);
    bad_read(4'd3);
    check("R8 read of clobbered reg3 errs", {63'd0, err_o}, 64'd1);
    do_start(CTX, FPV);
  endtask

  task automatic t_call_vs_write();
    logic [63:0] d;
    do_write(4'd6, 64'h0000_0000_0000_0AAA, 1'b1);
    call_done_i = 1'b1; ret_val_i = 64'h77;
    wr_en_i = 1'b1; wr_idx_i = 4'd6; wr_data_i = 64'hBBB; wr_wide_i = 1'b1;
    tick();
    call_done_i = 1'b0; wr_en_i = 1'b0;
    rd(4'd6, d); check("R10 write lost to call", d, 64'hAAA);
    rd(4'd0, d); check("R10 call still applied", d, 64'h77);
    call_done_i = 1'b1; ret_val_i = 64'h78;
    wr_en_i = 1'b1; wr_idx_i = 4'd10;
    tick();
    call_done_i = 1'b0; wr_en_i = 1'b0;
    check("R10 dropped reg10 write no err", {63'd0, err_o}, 64'd0);
    rd(4'd10, d); check("R10 reg10 unchanged", d, FPV);
  endtask

  task automatic t_start_priority();
    logic [63:0] d;
    do_write(4'd0, 64'h99, 1'b1);
    start_i = 1'b1; ctx_i = 64'h5151; fp_i = 64'h6161;
    call_done_i = 1'b1; ret_val_i = 64'h42;
    wr_en_i = 1'b1; wr_idx_i = 4'd1; wr_data_i = 64'h7777;
    tick();
    start_i = 1'b0; call_done_i = 1'b0; wr_en_i = 1'b0;
    rd(4'd1, d);  check("R2 start beats write", d, 64'h5151);
    rd(4'd0, d);  check("R2 start beats call", d, 64'd0);
    rd(4'd10, d); check("R2 fp reloaded", d, 64'h6161);
  endtask

  initial begin
    #(200000 * 5);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    t_reset();
    rst_ni = 1'b1;
    tick();
    t_reset();
    t_start();
    t_write_wide();
    t_write_narrow();
    t_bad_read();
    t_fp_write();
    t_call();
    t_call_vs_write();
    t_start_priority();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule